// File: doc/BRIEF.md
# DSP Mode Register Controller

This block keeps the upper byte of a signal processor's status register. That byte holds the interrupt priority mask, the data-path scaling mode, the trace enable and the loop-in-progress flag. Strobe inputs stand in for the instruction decoder and the interrupt controller. The block changes its bits in response to hardware and software reset, immediate OR and AND operations, loop entry and loop exit, long-interrupt entry and return from interrupt. Each of these events touches its own subset of the bits.

A small internal system stack holds saved mode bytes, so that loops and interrupts can nest. Loop exit takes back only the loop flag from the stack. Return from interrupt takes back the whole byte. The block also gives the interrupt controller a permit decision for a requested priority level, gives the data path a cleaned-up scaling code, and raises a trace-exception request when an instruction that began with tracing enabled completes.

Top module: `mode_reg_ctrl`

## Requirements
- R1: `mode_o` maps status-register bits 15..8 to bits 7..0, laid out as follows. Bit 0 is mask I0 and bit 1 is mask I1. Bit 2 is scale S0 and bit 3 is scale S1. Bit 5 is trace T and bit 7 is the loop flag LF. Bits 4 and 6 always read zero.
- R2: Hardware reset (`rst`, synchronous, active high) loads `mode_o` = 0x03 and empties the system stack.
- R3: A software reset clears S1, S0, T and LF. It leaves both mask bits unchanged and empties the system stack.
- R4: `irq_permit_o` is 1 exactly when `req_level_i` (0..3) is greater than or equal to the mask value {I1,I0}.
- R5: Long-interrupt entry pushes the full mode byte and then clears LF, T, S1 and S0. The mask bits are kept.
- R6: Return from interrupt pops the stack and restores every bit of the mode byte from the popped value.
- R7: Loop start pushes the mode byte and sets LF. Loop end pops the stack and restores only LF; all other bits are unchanged.
- R8: Immediate OR and immediate AND combine `imm_i` with the mode byte, using the bit layout of R1. Bits 4 and 6 stay zero afterwards.
- R9: When strobes coincide, only one event acts, in this priority order: software reset, interrupt entry, return from interrupt, loop start, loop end, OR, AND.
- R10: When an instruction begins (`instr_start_i`), the value of T at that moment is captured. If the captured value was 1, `trace_req_o` pulses for one cycle, one clock after `instr_done_i`. A later change of T does not affect the pending request.
- R11: The stack holds 15 entries. A push while full asserts `stk_ovf_o` in that cycle, and a pop while empty asserts `stk_unf_o` in that cycle. In either case the operation is dropped and `mode_o` does not change.
- R12: `scale_o` equals {S1,S0}, except that the reserved code 11 is output as 00. The stored bits in `mode_o` keep the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_reset_i | input | 1 | Software reset strobe |
| irq_enter_i | input | 1 | Long-interrupt entry strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| loop_start_i | input | 1 | Loop start strobe |
| loop_end_i | input | 1 | Loop end strobe (normal end or forced exit) |
| ori_i | input | 1 | Immediate OR strobe |
| andi_i | input | 1 | Immediate AND strobe |
| imm_i | input | 8 | Immediate operand for OR and AND |
| req_level_i | input | 2 | Priority level of a pending interrupt request |
| instr_start_i | input | 1 | Instruction begins execution |
| instr_done_i | input | 1 | Instruction completes |
| mode_o | output | 8 | Current mode byte |
| ipl_mask_o | output | 2 | Interrupt mask {I1,I0} |
| scale_o | output | 2 | Effective scaling code for the data path |
| irq_permit_o | output | 1 | Requested level is allowed |
| trace_req_o | output | 1 | Trace exception request pulse |
| stk_ovf_o | output | 1 | Push attempted while the stack is full |
| stk_unf_o | output | 1 | Pop attempted while the stack is empty |

## Verification
Some properties are checked on every cycle:
- the reserved bits stay zero;
- the hardware reset value is correct;
- the permit decision agrees with the mask;
- an uncontested interrupt entry clears its bits;
- an uncontested loop start sets LF;
- the mode byte stays frozen after a stack error;
- a trace request is only ever one cycle behind a completion.

Other behaviours can only be shown by the bench's scenarios, because they depend on sequences:
- which value comes back on return and on loop exit through nested pushes;
- the full 15-entry fill with overflow, followed by an unwind to underflow;
- the ranking of coincident strobes;
- T being captured at instruction start rather than at completion.

// File: rtl/mr_pkg.sv
package mr_pkg;

    localparam int MODE_W = 8;
    localparam int LVL_W  = 2;
    localparam logic [MODE_W-1:0] VALID_MASK = 8'hAF;
    localparam int IDX_T  = 5;
    localparam int IDX_LF = 7;

    typedef struct packed {
        logic             lf;
        logic             rsv_hi;
        logic             t;
        logic             rsv_lo;
        logic [1:0]       scale;
        logic [LVL_W-1:0] mask;
    } mode_t;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_DOWN = 2'b01,
        SC_UP   = 2'b10,
        SC_RSV  = 2'b11
    } scale_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_SWRST,
        EV_IRQ,
        EV_RTI,
        EV_LSTART,
        EV_LEND,
        EV_ORI,
        EV_ANDI
    } mr_event_e;

    localparam mode_t MODE_HW_RESET = '{lf: 1'b0, rsv_hi: 1'b0, t: 1'b0, rsv_lo: 1'b0,
                                        scale: 2'b00, mask: 2'b11};

    function automatic mode_t scrub(input logic [MODE_W-1:0] v);
        return mode_t'(v & VALID_MASK);
    endfunction

    function automatic logic level_permitted(input logic [LVL_W-1:0] lvl,
                                             input logic [LVL_W-1:0] mask);
        return (lvl >= mask);
    endfunction

    function automatic logic [1:0] eff_scale(input logic [1:0] s);
        return (scale_e'(s) == SC_RSV) ? SC_NONE : s;
    endfunction

endpackage

// File: rtl/mr_event_arb.sv
module mr_event_arb
    import mr_pkg::*;
(
    input  logic      sw_rst_i,
    input  logic      irq_i,
    input  logic      rti_i,
    input  logic      lstart_i,
    input  logic      lend_i,
    input  logic      ori_i,
    input  logic      andi_i,
    output mr_event_e ev_o
);

    always_comb begin
        if (sw_rst_i)      ev_o = EV_SWRST;
        else if (irq_i)    ev_o = EV_IRQ;
        else if (rti_i)    ev_o = EV_RTI;
        else if (lstart_i) ev_o = EV_LSTART;
        else if (lend_i)   ev_o = EV_LEND;
        else if (ori_i)    ev_o = EV_ORI;
        else if (andi_i)   ev_o = EV_ANDI;
        else               ev_o = EV_NONE;
    end

endmodule

// File: rtl/mr_sys_stack.sv
module mr_sys_stack #(
    parameter int DEPTH = 15,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] top_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o,
    output logic             unf_o
);

    localparam int PW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    cnt_q;
    logic             do_push;
    logic             do_pop;

    assign full_o  = (cnt_q == PW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign ovf_o   = push_i && full_o;
    assign unf_o   = pop_i && empty_o;
    assign top_o   = empty_o ? '0 : mem[cnt_q - 1'b1];

    always_ff @(posedge clk) begin
        if (rst || flush_i)
            cnt_q <= '0;
        else if (do_push)
            cnt_q <= cnt_q + 1'b1;
        else if (do_pop)
            cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush_i)
            mem[cnt_q] <= din_i;
    end

endmodule

// File: rtl/mr_trace_unit.sv
module mr_trace_unit (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    input  logic t_i,
    output logic req_o
);

    logic armed_q;
    logic armed_now;

    assign armed_now = start_i ? t_i : armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            req_o   <= 1'b0;
        end else begin
            armed_q <= armed_now;
            req_o   <= done_i && armed_now;
        end
    end

endmodule

// File: rtl/mode_reg_ctrl.sv
module mode_reg_ctrl
    import mr_pkg::*;
#(
    parameter int STACK_DEPTH = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_reset_i,
    input  logic        irq_enter_i,
    input  logic        rti_i,
    input  logic        loop_start_i,
    input  logic        loop_end_i,
    input  logic        ori_i,
    input  logic        andi_i,
    input  logic [7:0]  imm_i,
    input  logic [1:0]  req_level_i,
    input  logic        instr_start_i,
    input  logic        instr_done_i,
    output logic [7:0]  mode_o,
    output logic [1:0]  ipl_mask_o,
    output logic [1:0]  scale_o,
    output logic        irq_permit_o,
    output logic        trace_req_o,
    output logic        stk_ovf_o,
    output logic        stk_unf_o
);

    mode_t             mode_q;
    mode_t             mode_d;
    mr_event_e         ev;
    logic [MODE_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;
    logic              stk_push;
    logic              stk_pop;
    logic              stk_flush;

    mr_event_arb u_arb (
        .sw_rst_i (sw_reset_i),
        .irq_i    (irq_enter_i),
        .rti_i    (rti_i),
        .lstart_i (loop_start_i),
        .lend_i   (loop_end_i),
        .ori_i    (ori_i),
        .andi_i   (andi_i),
        .ev_o     (ev)
    );

    assign stk_push  = (ev == EV_IRQ) || (ev == EV_LSTART);
    assign stk_pop   = (ev == EV_RTI) || (ev == EV_LEND);
    assign stk_flush = (ev == EV_SWRST);

    mr_sys_stack #(
        .DEPTH (STACK_DEPTH),
        .WIDTH (MODE_W)
    ) u_stack (
        .clk     (clk),
        .rst     (rst),
        .flush_i (stk_flush),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .din_i   (mode_q),
        .top_o   (stk_top),
        .full_o  (stk_full),
        .empty_o (stk_empty),
        .ovf_o   (stk_ovf_o),
        .unf_o   (stk_unf_o)
    );

    always_comb begin
        mode_d = mode_q;
        case (ev)
            EV_SWRST: begin
                mode_d.scale = SC_NONE;
                mode_d.t     = 1'b0;
                mode_d.lf    = 1'b0;
            end
            EV_IRQ: begin
                if (!stk_full) begin
                    mode_d.scale = SC_NONE;
                    mode_d.t     = 1'b0;
                    mode_d.lf    = 1'b0;
                end
            end
            EV_RTI: begin
                if (!stk_empty)
                    mode_d = scrub(stk_top);
            end
            EV_LSTART: begin
                if (!stk_full)
                    mode_d.lf = 1'b1;
            end
            EV_LEND: begin
                if (!stk_empty)
                    mode_d.lf = stk_top[IDX_LF];
            end
            EV_ORI:  mode_d = scrub(mode_q | imm_i);
            EV_ANDI: mode_d = scrub(mode_q & imm_i);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_HW_RESET;
        else
            mode_q <= mode_d;
    end

    mr_trace_unit u_trace (
        .clk     (clk),
        .rst     (rst),
        .start_i (instr_start_i),
        .done_i  (instr_done_i),
        .t_i     (mode_q.t),
        .req_o   (trace_req_o)
    );

    assign mode_o       = mode_q;
    assign ipl_mask_o   = mode_q.mask;
    assign scale_o      = eff_scale(mode_q.scale);
    assign irq_permit_o = level_permitted(req_level_i, mode_q.mask);

endmodule

// File: rtl/mr_mode_chk.sv
module mr_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       sw_reset_i,
    input logic       irq_enter_i,
    input logic       rti_i,
    input logic       loop_start_i,
    input logic       instr_done_i,
    input logic [1:0] req_level_i,
    input logic [7:0] mode_o,
    input logic [1:0] scale_o,
    input logic       irq_permit_o,
    input logic       trace_req_o,
    input logic       stk_ovf_o,
    input logic       stk_unf_o
);

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o[6] == 1'b0) && (mode_o[4] == 1'b0));

    p_hw_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_o == 8'h03));

    p_permit_r4: assert property (@(posedge clk) disable iff (rst)
        irq_permit_o == (req_level_i >= mode_o[1:0]));

    p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_enter_i && !sw_reset_i && !stk_ovf_o)
        |=> ((mode_o[7:2] == 6'd0) && (mode_o[1:0] == $past(mode_o[1:0]))));

    p_loop_set_r7: assert property (@(posedge clk) disable iff (rst)
        (loop_start_i && !sw_reset_i && !irq_enter_i && !rti_i && !stk_ovf_o)
        |=> mode_o[7]);

    p_trace_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        trace_req_o |-> $past(instr_done_i));

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
        stk_ovf_o |=> $stable(mode_o));

    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        stk_unf_o |=> $stable(mode_o));

    p_scale_clean_r12: assert property (@(posedge clk) disable iff (rst)
        scale_o != 2'b11);

endmodule

bind mode_reg_ctrl mr_mode_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sw_reset_i   (sw_reset_i),
    .irq_enter_i  (irq_enter_i),
    .rti_i        (rti_i),
    .loop_start_i (loop_start_i),
    .instr_done_i (instr_done_i),
    .req_level_i  (req_level_i),
    .mode_o       (mode_o),
    .scale_o      (scale_o),
    .irq_permit_o (irq_permit_o),
    .trace_req_o  (trace_req_o),
    .stk_ovf_o    (stk_ovf_o),
    .stk_unf_o    (stk_unf_o)
);

// File: tb/tb_mode_reg_ctrl.sv
`timescale 1ns/1ps
module tb_mode_reg_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_reset_i = 0, irq_enter_i = 0, rti_i = 0;
    logic       loop_start_i = 0, loop_end_i = 0, ori_i = 0, andi_i = 0;
    logic [7:0] imm_i = 8'h00;
    logic [1:0] req_level_i = 2'd0;
    logic       instr_start_i = 0, instr_done_i = 0;
    logic [7:0] mode_o;
    logic [1:0] ipl_mask_o, scale_o;
    logic       irq_permit_o, trace_req_o, stk_ovf_o, stk_unf_o;

    always #10 clk = ~clk;

    mode_reg_ctrl dut (
        .clk(clk), .rst(rst), .sw_reset_i(sw_reset_i), .irq_enter_i(irq_enter_i),
        .rti_i(rti_i), .loop_start_i(loop_start_i), .loop_end_i(loop_end_i),
        .ori_i(ori_i), .andi_i(andi_i), .imm_i(imm_i), .req_level_i(req_level_i),
        .instr_start_i(instr_start_i), .instr_done_i(instr_done_i),
        .mode_o(mode_o), .ipl_mask_o(ipl_mask_o), .scale_o(scale_o),
        .irq_permit_o(irq_permit_o), .trace_req_o(trace_req_o),
        .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    typedef struct {
        string      req;
        logic [7:0] mode;
        logic       trace;
    } exp_t;

    exp_t       sb_q[$];
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 0;
    logic [7:0] m_mode = 8'h03;
    logic [7:0] m_stk[$];
    logic       m_armed = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares registered outputs away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, mode_o, e.mode);
                chk({e.req, " trace"}, {7'd0, trace_req_o}, {7'd0, e.trace});
            end
        end
    end

    task automatic clear_in();
        sw_reset_i = 0; irq_enter_i = 0; rti_i = 0; loop_start_i = 0;
        loop_end_i = 0; ori_i = 0; andi_i = 0; imm_i = 8'h00;
        instr_start_i = 0; instr_done_i = 0;
    endtask

    // driver: strobes are set at a falling edge before calling
    task automatic cyc(input string req);
        logic [7:0] nm;
        logic [7:0] v;
        logic       ovf_e, unf_e, armed_now;
        exp_t       e;
        #1;
        nm = m_mode; ovf_e = 0; unf_e = 0;
        if (sw_reset_i) begin
            nm = m_mode & 8'h03; m_stk.delete();
        end else if (irq_enter_i) begin
            if (m_stk.size() == 15) ovf_e = 1;
            else begin m_stk.push_back(m_mode); nm = m_mode & 8'h03; end
        end else if (rti_i) begin
            if (m_stk.size() == 0) unf_e = 1;
            else nm = m_stk.pop_back();
        end else if (loop_start_i) begin
            if (m_stk.size() == 15) ovf_e = 1;
            else begin m_stk.push_back(m_mode); nm = m_mode | 8'h80; end
        end else if (loop_end_i) begin
            if (m_stk.size() == 0) unf_e = 1;
            else begin v = m_stk.pop_back(); nm = {v[7], m_mode[6:0]}; end
        end else if (ori_i) begin
            nm = (m_mode | imm_i) & 8'hAF;
        end else if (andi_i) begin
            nm = m_mode & imm_i;
        end
        chk({req, " ovf"}, {7'd0, stk_ovf_o}, {7'd0, ovf_e});
        chk({req, " unf"}, {7'd0, stk_unf_o}, {7'd0, unf_e});
        armed_now = instr_start_i ? m_mode[5] : m_armed;
        m_armed   = armed_now;
        e.req = req; e.mode = nm; e.trace = instr_done_i & armed_now;
        sb_q.push_back(e);
        m_mode = nm;
        @(negedge clk);
        clear_in();
    endtask

    task automatic permit_all(input string req);
        for (int l = 0; l < 4; l++) begin
            req_level_i = 2'(l);
            #1;
            chk(req, {7'd0, irq_permit_o}, {7'd0, (l >= int'(m_mode[1:0]))});
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R2 reset value", mode_o, 8'h03);
        permit_all("R4 mask 3");

        andi_i = 1; imm_i = 8'h00; cyc("R8 andi clear");
        permit_all("R4 mask 0");
        ori_i = 1; imm_i = 8'hFF; cyc("R8 ori all, R1 reserved zero");
        chk("R12 reserved scale", {6'd0, scale_o}, 8'h00);
        andi_i = 1; imm_i = 8'h21; cyc("R8 andi keep T,I0");

        // R10 trace
        instr_start_i = 1; cyc("R10 start T=1");
        instr_done_i = 1; cyc("R10 done raises trace");
        cyc("R10 idle");
        instr_start_i = 1; cyc("R10 start T=1 again");
        andi_i = 1; imm_i = 8'h01; cyc("R10 clear T mid instr");
        instr_done_i = 1; cyc("R10 trace uses start value");
        instr_start_i = 1; instr_done_i = 1; cyc("R10 T=0 no trace");

        // R7 nested loops
        ori_i = 1; imm_i = 8'h20; cyc("R8 set T");
        loop_start_i = 1; cyc("R7 loop start 1");
        loop_start_i = 1; cyc("R7 loop start 2");
        loop_end_i = 1; cyc("R7 loop end inner");
        loop_end_i = 1; cyc("R7 loop end outer");

        // R5 / R6
        ori_i = 1; imm_i = 8'h8C; cyc("R8 ori 8C");
        irq_enter_i = 1; cyc("R5 irq entry");
        rti_i = 1; cyc("R6 rti full restore");
        rti_i = 1; cyc("R11 rti underflow");
        loop_end_i = 1; cyc("R11 loop end underflow");

        // R9 priority
        irq_enter_i = 1; ori_i = 1; imm_i = 8'h02; cyc("R9 irq over ori");
        rti_i = 1; loop_start_i = 1; cyc("R9 rti over loop start");
        loop_start_i = 1; loop_end_i = 1; andi_i = 1; imm_i = 8'h00; cyc("R9 loop start over end");
        loop_end_i = 1; cyc("R7 loop end LF");
        sw_reset_i = 1; irq_enter_i = 1; cyc("R9 sw reset over irq, R3");
        rti_i = 1; cyc("R3 stack emptied");

        // R3 mask kept
        ori_i = 1; imm_i = 8'h06; cyc("R8 ori 06");
        chk("R12 scale down", {6'd0, scale_o}, 8'h01);
        sw_reset_i = 1; cyc("R3 sw reset keeps mask");
        permit_all("R4 mask 3 after sw reset");

        // R11 overflow
        ori_i = 1; imm_i = 8'h04; cyc("R8 ori 04");
        for (int i = 0; i < 15; i++) begin
            loop_start_i = 1; cyc("R11 fill");
        end
        loop_start_i = 1; cyc("R11 loop start overflow");
        irq_enter_i = 1; cyc("R11 irq overflow");
        for (int i = 0; i < 15; i++) begin
            loop_end_i = 1; cyc("R11 unwind");
        end
        loop_end_i = 1; cyc("R11 unwind underflow");
        andi_i = 1; imm_i = 8'h06; cyc("R8 andi 06");
        permit_all("R4 mask 2");

        // R2 hardware reset mid run
        ori_i = 1; imm_i = 8'hA0; cyc("R8 ori A0");
        loop_start_i = 1; cyc("R7 push before reset");
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_mode = 8'h03; m_stk.delete(); m_armed = 0;
        chk("R2 hw reset mid run", mode_o, 8'h03);
        rti_i = 1; cyc("R2 stack emptied by hw reset");

        @(posedge clk);
        #5;
        finish_run();
    end

endmodule